// File: doc/BRIEF.md
# Virtualized ID Register Access Unit

This block holds a 32-bit virtual processor-ID register and answers the move-to and move-from requests aimed at two coprocessor encodings. One encoding addresses the virtual ID register. The other addresses the fixed main ID value, which is set by a parameter. The block takes a request that decode has already split into coprocessor number, opc1, CRn, CRm and opc2. In the same cycle it returns the read data, an undefined-instruction flag, or a trap-to-hypervisor flag with a syndrome code.

Access depends on the current exception level, the hypervisor enable and presence flags, a hypervisor trap bit and the non-secure bit. At level 1 a guest that reads the main ID encoding gets the value the hypervisor programmed, not the real identity of the processor. The register holds five fields: implementer [31:24], variant [23:20], architecture [19:16], part number [15:4] and revision [3:0]. The block stores the word whole and does not interpret these fields.

Top module: `virt_id_access`

## Requirements
- R1: An encoding counts as a hit only when the coprocessor is 15 and CRn, CRm and opc2 are all 0. With those values, opc1 = 4 selects the virtual ID encoding and opc1 = 0 selects the main ID encoding. Any other request drives all outputs to zero and leaves the register unchanged.
- R2: At level 0, every access to either encoding raises undefined.
- R3: At level 1, if the hypervisor is enabled and the trap bit is set, every access to either encoding raises trap with syndrome code 0x03 and does not raise undefined.
- R4: At level 1, an untrapped access to the virtual ID encoding raises undefined.
- R5: At level 1, an untrapped read of the main ID encoding returns the virtual ID register when the hypervisor is enabled, and the parameter main ID value otherwise.
- R6: At level 2, a read of the virtual ID encoding returns the register. A write stores the data word, and the new value is visible from the next cycle.
- R7: At level 3 with no hypervisor present, a read of the virtual ID encoding returns the main ID value. A write is ignored and raises no flag.
- R8: At level 3 with a hypervisor present, a virtual ID access raises undefined when the non-secure bit is 0. When the bit is 1, reads and writes act on the register.
- R9: At levels 2 and 3, a read of the main ID encoding returns the main ID value. A write to the main ID encoding raises undefined at every level whenever it is not trapped.
- R10: After reset, the virtual ID register holds the main ID value.
- R11: When a request is valid, undefined and trap are never both raised. With no valid request both flags are low. Read data is zero unless a read completes, and the syndrome code is zero unless trap is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = move to register, 0 = move from register |
| req_cp | input | 4 | Coprocessor number |
| req_op1 | input | 3 | opc1 field |
| req_crn | input | 4 | CRn field |
| req_crm | input | 4 | CRm field |
| req_op2 | input | 3 | opc2 field |
| wr_data | input | 32 | Write data word |
| cur_el | input | 2 | Current exception level 0..3 |
| hyp_enabled | input | 1 | Hypervisor level enabled for current state |
| hyp_present | input | 1 | Hypervisor level implemented |
| hyp_trap | input | 1 | Hypervisor trap bit for these encodings |
| nonsecure | input | 1 | Non-secure state bit |
| rd_data | output | 32 | Read result |
| undef_o | output | 1 | Undefined instruction |
| trap_o | output | 1 | Trap to hypervisor |
| trap_code | output | 6 | Syndrome code, valid with trap_o |

## Verification
The bench targets these corner cases:
- **Level 1 redirect.** A design that returned the real identity here would let a guest see through the hypervisor.
- **Trap versus undefined priority at level 1.** Testing the undefined condition first would swallow the trap.
- **Write at level 3 with no hypervisor present.** A design that committed this write would change what level 2 reads later.
- **Secure-state lockout at level 3.** This also checks that writes to the main ID encoding never reach the register.
- **Near-miss encodings.** Requests that differ from a hit in a single field catch a decoder that ignores one field and answers a stray request.

// File: rtl/virt_id_access.sv
module virt_id_access #(
  parameter logic [31:0] MAIN_ID   = 32'h5A2F_D134,
  parameter logic [5:0]  TRAP_CODE = 6'h03
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [3:0]  req_cp,
  input  logic [2:0]  req_op1,
  input  logic [3:0]  req_crn,
  input  logic [3:0]  req_crm,
  input  logic [2:0]  req_op2,
  input  logic [31:0] wr_data,
  input  logic [1:0]  cur_el,
  input  logic        hyp_enabled,
  input  logic        hyp_present,
  input  logic        hyp_trap,
  input  logic        nonsecure,
  output logic [31:0] rd_data,
  output logic        undef_o,
  output logic        trap_o,
  output logic [5:0]  trap_code
);

  logic [31:0] vid_q;
  logic        base_ok, is_vid, is_main, hit;
  logic        undef_c, trap_c, commit_c;
  logic [31:0] rd_c;

  assign base_ok = req_valid && req_cp == 4'hF && req_crn == 4'h0 &&
                   req_crm == 4'h0 && req_op2 == 3'h0;
  assign is_vid  = base_ok && req_op1 == 3'b100;
  assign is_main = base_ok && req_op1 == 3'b000;
  assign hit     = is_vid || is_main;

  always_comb begin
    undef_c  = 1'b0;
    trap_c   = 1'b0;
    commit_c = 1'b0;
    rd_c     = '0;
    if (hit) begin
      case (cur_el)
        2'd0: undef_c = 1'b1;
        2'd1: begin
          if (hyp_enabled && hyp_trap) trap_c = 1'b1;
          else if (is_vid || req_write) undef_c = 1'b1;
          else rd_c = hyp_enabled ? vid_q : MAIN_ID;
        end
        default: begin
          if (is_main) begin
            if (req_write) undef_c = 1'b1;
            else rd_c = MAIN_ID;
          end else if (cur_el == 2'd3 && !hyp_present) begin
            if (!req_write) rd_c = MAIN_ID;
          end else if (cur_el == 2'd3 && !nonsecure) begin
            undef_c = 1'b1;
          end else if (req_write) begin
            commit_c = 1'b1;
          end else begin
            rd_c = vid_q;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        vid_q <= MAIN_ID;
    else if (commit_c) vid_q <= wr_data;
  end

  assign rd_data   = rd_c;
  assign undef_o   = undef_c;
  assign trap_o    = trap_c;
  assign trap_code = trap_c ? TRAP_CODE : 6'h00;

  // R11
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(undef_o && trap_o));
  // R11
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!undef_o && !trap_o && rd_data == 32'h0));
  // R3
  code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> (trap_code == TRAP_CODE && cur_el == 2'd1));
  // R2
  el0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cur_el == 2'd0) |-> (!trap_o && rd_data == 32'h0));
  // R6
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_write && is_vid && (cur_el == 2'd2 ||
      (cur_el == 2'd3 && hyp_present && nonsecure)))
    |=> vid_q == $past(wr_data));
  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_write && is_vid && cur_el[1]) |=> $stable(vid_q));

endmodule

// File: tb/virt_id_access_tb.sv
module virt_id_access_tb_top;
  localparam logic [31:0] MID = 32'h5A2F_D134;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0;
  logic [3:0] req_cp = 0, req_crn = 0, req_crm = 0;
  logic [2:0] req_op1 = 0, req_op2 = 0;
  logic [31:0] wr_data = 0;
  logic [1:0] cur_el = 0;
  logic hyp_enabled = 0, hyp_present = 0, hyp_trap = 0, nonsecure = 0;
  logic [31:0] rd_data;
  logic undef_o, trap_o;
  logic [5:0] trap_code;

  int checks = 0, errors = 0;
  logic [31:0] model_q = MID;

  always #4 clk = ~clk;

  virt_id_access #(.MAIN_ID(MID)) dut_i (.*);

  function automatic string tag_of(bit v, bit w, bit isv, bit ism, logic [1:0] el,
                                   bit he, bit hp, bit ht);
    if (!v) return "R11";
    if (!(isv || ism)) return "R1";
    if (el == 0) return "R2";
    if (el == 1) begin
      if (he && ht) return "R3";
      if (isv) return "R4";
      return w ? "R9" : "R5";
    end
    if (ism) return "R9";
    if (el == 2) return "R6";
    return hp ? "R8" : "R7";
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic req(bit v, bit w, logic [3:0] cp, logic [2:0] o1, logic [3:0] n,
                     logic [3:0] m, logic [2:0] o2, logic [31:0] d, logic [1:0] el,
                     bit he, bit hp, bit ht, bit ns, string force_tag);
    bit isv, ism, hit, eu, et, cm;
    logic [31:0] er;
    string tg;
    @(negedge clk);
    req_valid = v; req_write = w; req_cp = cp; req_op1 = o1; req_crn = n;
    req_crm = m; req_op2 = o2; wr_data = d; cur_el = el;
    hyp_enabled = he; hyp_present = hp; hyp_trap = ht; nonsecure = ns;
    isv = v && cp == 15 && n == 0 && m == 0 && o2 == 0 && o1 == 4;
    ism = v && cp == 15 && n == 0 && m == 0 && o2 == 0 && o1 == 0;
    hit = isv || ism;
    eu = 0; et = 0; cm = 0; er = 0;
    if (hit) begin
      if (el == 0) eu = 1;
      else if (el == 1) begin
        if (he && ht) et = 1;
        else if (isv || w) eu = 1;
        else er = he ? model_q : MID;
      end else if (ism) begin
        if (w) eu = 1; else er = MID;
      end else if (el == 3 && !hp) begin
        if (!w) er = MID;
      end else if (el == 3 && !ns) eu = 1;
      else if (w) cm = 1;
      else er = model_q;
    end
    tg = (force_tag != "") ? force_tag : tag_of(v, w, isv, ism, el, he, hp, ht);
    #2;
    check(tg, "undef", {31'b0, undef_o}, {31'b0, eu});
    check(tg, "trap", {31'b0, trap_o}, {31'b0, et});
    check(tg, "code", {26'b0, trap_code}, et ? 32'h3 : 32'h0);
    check(tg, "rd", rd_data, er);
    if (cm) model_q = d;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: reset value read at level 2
    req(1, 0, 15, 4, 0, 0, 0, 0, 2, 1, 1, 0, 1, "R10");
    // R2 level 0
    req(1, 0, 15, 0, 0, 0, 0, 0, 0, 1, 1, 0, 1, "R2");
    // R6 write then read back
    req(1, 1, 15, 4, 0, 0, 0, 32'hCAFE_0123, 2, 1, 1, 0, 1, "R6");
    req(1, 0, 15, 4, 0, 0, 0, 0, 2, 1, 1, 0, 1, "R6");
    // R5 redirect and direct
    req(1, 0, 15, 0, 0, 0, 0, 0, 1, 1, 1, 0, 1, "R5");
    req(1, 0, 15, 0, 0, 0, 0, 0, 1, 0, 1, 0, 1, "R5");
    // R3 trap wins over undef on the virtual encoding
    req(1, 1, 15, 4, 0, 0, 0, 0, 1, 1, 1, 1, 1, "R3");
    // R4
    req(1, 0, 15, 4, 0, 0, 0, 0, 1, 1, 1, 0, 1, "R4");
    // R7 ignored write, then observe at level 2
    req(1, 1, 15, 4, 0, 0, 0, 32'h1111_2222, 3, 0, 0, 0, 1, "R7");
    req(1, 0, 15, 4, 0, 0, 0, 0, 3, 0, 0, 0, 1, "R7");
    req(1, 0, 15, 4, 0, 0, 0, 0, 2, 1, 1, 0, 1, "R7");
    // R8 secure lockout and nonsecure write
    req(1, 1, 15, 4, 0, 0, 0, 32'h3333_4444, 3, 1, 1, 0, 0, "R8");
    req(1, 0, 15, 4, 0, 0, 0, 0, 2, 1, 1, 0, 1, "R8");
    req(1, 1, 15, 4, 0, 0, 0, 32'h5555_6666, 3, 1, 1, 0, 1, "R8");
    req(1, 0, 15, 4, 0, 0, 0, 0, 3, 1, 1, 0, 1, "R8");
    // R9 main encoding writes undefined, reads fixed
    req(1, 1, 15, 0, 0, 0, 0, 32'h7777_8888, 2, 1, 1, 0, 1, "R9");
    req(1, 0, 15, 0, 0, 0, 0, 0, 3, 1, 1, 0, 1, "R9");
    // R1 near misses, one field off each
    req(1, 1, 14, 4, 0, 0, 0, 32'h9, 2, 1, 1, 0, 1, "R1");
    req(1, 1, 15, 4, 1, 0, 0, 32'h9, 2, 1, 1, 0, 1, "R1");
    req(1, 1, 15, 4, 0, 2, 0, 32'h9, 2, 1, 1, 0, 1, "R1");
    req(1, 1, 15, 4, 0, 0, 1, 32'h9, 2, 1, 1, 0, 1, "R1");
    req(1, 1, 15, 5, 0, 0, 0, 32'h9, 2, 1, 1, 0, 1, "R1");
    req(1, 0, 15, 4, 0, 0, 0, 0, 2, 1, 1, 0, 1, "R1");
    // R11 idle
    req(0, 1, 15, 4, 0, 0, 0, 32'hAB, 2, 1, 1, 0, 1, "R11");
    for (int i = 0; i < 3000; i++) begin
      int k;
      logic [3:0] cp, n, m;
      logic [2:0] o1, o2;
      k = $urandom % 8;
      cp = 15; n = 0; m = 0; o2 = 0;
      o1 = ($urandom % 2) ? 3'd4 : 3'd0;
      if (k == 0) begin
        cp = 4'($urandom); n = 4'($urandom % 2); m = 4'($urandom % 2);
        o2 = 3'($urandom % 2); o1 = 3'($urandom);
      end
      req(($urandom % 8) != 0, $urandom % 2, cp, o1, n, m, o2, $urandom,
          2'($urandom), $urandom % 2, $urandom % 2, ($urandom % 3) == 0,
          $urandom % 2, "");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule